// File: doc/BRIEF.md
# Coalescing Transfer Request Queue

This block holds the transmit work for a byte-stream engine. It keeps at most two requests, an active one and one pending behind it. Each request is a start address and an even byte length. When a new request starts exactly where a held request ends, the block folds it into that request instead of using a slot. A long run of back-to-back buffers therefore shows up as one growing transfer.

A fetch side walks the active request in chunks of 16-bit words. Each chunk is offered as an address and a word count, with a valid/ready handshake. When the last byte of the active request has been handed out, the pending request takes its place on the same clock edge. A query port tells software or a neighbouring block whether a given byte address still waits to be fetched. A status output shows when all work has drained.

Top module: `xfer_coalesce_queue`

## Requirements
- R1: After reset, `queue_done` is 1, `chunk_valid` is 0 and `qry_pending` is 0 for any query address.
- R2: A request with an odd length (bit 0 of `req_len` set) is never accepted: `req_ready` is 0. A request of length zero is accepted and changes no state.
- R3: While the queue is empty, any even nonzero request is accepted. From the next cycle it is the active request with nothing consumed: `chunk_addr` equals its start address.
- R4: When the pending slot is empty and the request start equals active start plus active length, the request is accepted and the active length grows by the request length.
- R5: When the pending slot is full and the request start equals pending start plus pending length, the request is accepted and the pending length grows by the request length.
- R6: When the pending slot is empty and the request is not contiguous with the active one, the request is accepted into the pending slot.
- R7: When the pending slot is full and the request does not continue it, `req_ready` is 0. This holds even if the request continues the active request.
- R8: `chunk_valid` is 1 while the active request has bytes left. `chunk_addr` is the active start plus the bytes consumed so far. `chunk_words` is the smaller of 128 (MAX_WORDS) and half the remaining bytes. Each handshake consumes `2*chunk_words` bytes.
- R9: While `chunk_valid` is 1 and `chunk_ready` is 0, the offered `chunk_addr` does not change.
- R10: When a handshake consumes the last active byte, the pending request becomes active on that edge, with nothing consumed, and the pending slot empties.
- R11: `qry_pending` is 1 when `qry_addr` lies in the unconsumed part of the active request, or anywhere within the pending request. Otherwise it is 0.
- R12: `queue_done` is 1 exactly when there is no active work and the pending slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request offered |
| req_addr | input | ADDR_W | Request start byte address |
| req_len | input | LEN_W | Request length in bytes |
| req_ready | output | 1 | Request accepted this cycle when valid |
| chunk_valid | output | 1 | A chunk of the active request is offered |
| chunk_addr | output | ADDR_W | Chunk start byte address |
| chunk_words | output | $clog2(MAX_WORDS+1) | Chunk size in 16-bit words |
| chunk_ready | input | 1 | Consumer takes the offered chunk |
| qry_addr | input | ADDR_W | Address to look up |
| qry_pending | output | 1 | Queried address still outstanding |
| queue_done | output | 1 | No active or pending work |

## Verification
`req_ready`, the chunk outputs, `qry_pending` and `queue_done` are combinational functions of the held slots and the present inputs. A decision is therefore visible in the same cycle as its stimulus. Its effect on the slots appears one rising edge later. The bench drives inputs on the falling edge and compares every output one time unit after that, against a model of the two slots. It then advances the model by the handshakes that the coming rising edge will complete. The directed checks on merging, holding and promotion read the outputs in the cycle that follows the accepting edge.

// File: rtl/xcq_pkg.sv
package xcq_pkg;

    localparam int unsigned WORD_BYTES = 2;

    typedef enum logic [2:0] {
        OP_REJECT,
        OP_DROP,
        OP_LOAD,
        OP_GROW_ACT,
        OP_GROW_PND,
        OP_STORE_PND
    } merge_op_e;

    // words in the next chunk: remaining bytes as words, capped
    function automatic int unsigned chunk_word_count(int unsigned rem_bytes,
                                                     int unsigned max_words);
        int unsigned w;
        w = rem_bytes / WORD_BYTES;
        return (w > max_words) ? max_words : w;
    endfunction

endpackage

// File: rtl/xcq_merge.sv
module xcq_merge import xcq_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 20
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] act_base,
    input  logic [LEN_W-1:0]  act_len,
    input  logic              pnd_valid,
    input  logic [ADDR_W-1:0] pnd_base,
    input  logic [LEN_W-1:0]  pnd_len,
    output merge_op_e         op,
    output logic              accept
);
    logic              empty;
    logic [ADDR_W-1:0] act_end;
    logic [ADDR_W-1:0] pnd_end;

    assign empty   = (act_len == '0) && !pnd_valid;
    assign act_end = act_base + ADDR_W'(act_len);
    assign pnd_end = pnd_base + ADDR_W'(pnd_len);

    always_comb begin
        if (req_len[0])
            op = OP_REJECT;
        else if (req_len == '0)
            op = OP_DROP;
        else if (empty)
            op = OP_LOAD;
        else if (!pnd_valid && req_addr == act_end)
            op = OP_GROW_ACT;
        else if (pnd_valid && req_addr == pnd_end)
            op = OP_GROW_PND;
        else if (!pnd_valid)
            op = OP_STORE_PND;
        else
            op = OP_REJECT;
    end

    assign accept = (op != OP_REJECT);
endmodule

// File: rtl/xcq_fetch.sv
module xcq_fetch import xcq_pkg::*; #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 20,
    parameter int MAX_WORDS = 128,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic [ADDR_W-1:0] act_base,
    input  logic [LEN_W-1:0]  act_len,
    input  logic [LEN_W-1:0]  act_used,
    output logic              chunk_valid,
    output logic [ADDR_W-1:0] chunk_addr,
    output logic [CNT_W-1:0]  chunk_words,
    output logic [LEN_W-1:0]  chunk_bytes
);
    logic [LEN_W-1:0] rem;
    int unsigned      words;

    assign rem         = act_len - act_used;
    assign chunk_valid = (rem != '0);
    assign chunk_addr  = act_base + ADDR_W'(act_used);

    always_comb begin
        words = chunk_word_count(32'(rem), MAX_WORDS);
    end

    assign chunk_words = CNT_W'(words);
    assign chunk_bytes = LEN_W'(words * WORD_BYTES);
endmodule

// File: rtl/xcq_query.sv
module xcq_query #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 20,
    localparam int EXT_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] qry_addr,
    input  logic [ADDR_W-1:0] act_base,
    input  logic [LEN_W-1:0]  act_len,
    input  logic [LEN_W-1:0]  act_used,
    input  logic              pnd_valid,
    input  logic [ADDR_W-1:0] pnd_base,
    input  logic [LEN_W-1:0]  pnd_len,
    output logic              hit
);
    logic [EXT_W-1:0] q, act_lo, act_hi, pnd_lo, pnd_hi;
    logic             in_act, in_pnd;

    assign q      = {1'b0, qry_addr};
    assign act_lo = {1'b0, act_base} + EXT_W'(act_used);
    assign act_hi = {1'b0, act_base} + EXT_W'(act_len);
    assign pnd_lo = {1'b0, pnd_base};
    assign pnd_hi = {1'b0, pnd_base} + EXT_W'(pnd_len);

    assign in_act = (act_used != act_len) && (q >= act_lo) && (q < act_hi);
    assign in_pnd = pnd_valid && (q >= pnd_lo) && (q < pnd_hi);
    assign hit    = in_act || in_pnd;
endmodule

// File: rtl/xfer_coalesce_queue.sv
module xfer_coalesce_queue import xcq_pkg::*; #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 20,
    parameter int MAX_WORDS = 128,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    output logic              chunk_valid,
    output logic [ADDR_W-1:0] chunk_addr,
    output logic [CNT_W-1:0]  chunk_words,
    input  logic              chunk_ready,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_pending,
    output logic              queue_done
);
    // slot state
    logic [ADDR_W-1:0] act_base, pnd_base;
    logic [LEN_W-1:0]  act_len, act_used, pnd_len;
    logic              pnd_valid;

    // next state
    logic [ADDR_W-1:0] n_act_base, n_pnd_base;
    logic [LEN_W-1:0]  n_act_len, n_act_used, n_pnd_len;
    logic              n_pnd_valid;

    merge_op_e        op;
    logic [LEN_W-1:0] chunk_bytes;
    logic             req_fire, chunk_fire;

    xcq_merge #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_merge (
        .req_addr (req_addr),
        .req_len  (req_len),
        .act_base (act_base),
        .act_len  (act_len),
        .pnd_valid(pnd_valid),
        .pnd_base (pnd_base),
        .pnd_len  (pnd_len),
        .op       (op),
        .accept   (req_ready)
    );

    xcq_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS)) u_fetch (
        .act_base   (act_base),
        .act_len    (act_len),
        .act_used   (act_used),
        .chunk_valid(chunk_valid),
        .chunk_addr (chunk_addr),
        .chunk_words(chunk_words),
        .chunk_bytes(chunk_bytes)
    );

    xcq_query #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_query (
        .qry_addr (qry_addr),
        .act_base (act_base),
        .act_len  (act_len),
        .act_used (act_used),
        .pnd_valid(pnd_valid),
        .pnd_base (pnd_base),
        .pnd_len  (pnd_len),
        .hit      (qry_pending)
    );

    assign req_fire   = req_valid && req_ready;
    assign chunk_fire = chunk_valid && chunk_ready;
    assign queue_done = (act_len == '0) && !pnd_valid;

    always_comb begin
        n_act_base  = act_base;
        n_act_len   = act_len;
        n_act_used  = act_used;
        n_pnd_valid = pnd_valid;
        n_pnd_base  = pnd_base;
        n_pnd_len   = pnd_len;

        // request side first
        if (req_fire) begin
            case (op)
                OP_LOAD: begin
                    n_act_base = req_addr;
                    n_act_len  = req_len;
                    n_act_used = '0;
                end
                OP_GROW_ACT:  n_act_len = act_len + req_len;
                OP_GROW_PND:  n_pnd_len = pnd_len + req_len;
                OP_STORE_PND: begin
                    n_pnd_valid = 1'b1;
                    n_pnd_base  = req_addr;
                    n_pnd_len   = req_len;
                end
                default: ;
            endcase
        end

        // then consumption
        if (chunk_fire)
            n_act_used = act_used + chunk_bytes;

        // then promotion on exhaustion
        if (n_act_len != '0 && n_act_used == n_act_len) begin
            if (n_pnd_valid) begin
                n_act_base  = n_pnd_base;
                n_act_len   = n_pnd_len;
                n_act_used  = '0;
                n_pnd_valid = 1'b0;
                n_pnd_len   = '0;
            end else begin
                n_act_len  = '0;
                n_act_used = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_base  <= '0;
            act_len   <= '0;
            act_used  <= '0;
            pnd_valid <= 1'b0;
            pnd_base  <= '0;
            pnd_len   <= '0;
        end else begin
            act_base  <= n_act_base;
            act_len   <= n_act_len;
            act_used  <= n_act_used;
            pnd_valid <= n_pnd_valid;
            pnd_base  <= n_pnd_base;
            pnd_len   <= n_pnd_len;
        end
    end
endmodule

// File: rtl/xcq_chk.sv
module xcq_chk #(
    parameter int ADDR_W    = 32,
    parameter int MAX_WORDS = 128,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_len_lsb,
    input logic              req_ready,
    input logic              chunk_valid,
    input logic              chunk_ready,
    input logic [ADDR_W-1:0] chunk_addr,
    input logic [CNT_W-1:0]  chunk_words,
    input logic              qry_pending,
    input logic              queue_done
);
    // R2
    odd_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_len_lsb) |-> !req_ready);

    // R3
    idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (queue_done && req_valid && !req_len_lsb) |-> req_ready);

    // R8
    chunk_size_chk: assert property (@(posedge clk) disable iff (rst)
        chunk_valid |-> (chunk_words != '0 && 32'(chunk_words) <= MAX_WORDS));

    // R9
    chunk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && !chunk_ready) |=> (chunk_valid && $stable(chunk_addr)));

    // R12
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        queue_done |-> (!chunk_valid && !qry_pending));
endmodule

bind xfer_coalesce_queue xcq_chk #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_len_lsb(req_len[0]),
    .req_ready  (req_ready),
    .chunk_valid(chunk_valid),
    .chunk_ready(chunk_ready),
    .chunk_addr (chunk_addr),
    .chunk_words(chunk_words),
    .qry_pending(qry_pending),
    .queue_done (queue_done)
);

// File: tb/test_xfer_coalesce_queue.sv
module test_xfer_coalesce_queue;
    localparam int CLK_PERIOD = 10;
    localparam int MAXW       = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [19:0] req_len = '0;
    logic        req_ready;
    logic        chunk_valid;
    logic [31:0] chunk_addr;
    logic [7:0]  chunk_words;
    logic        chunk_ready = 1'b0;
    logic [31:0] qry_addr = '0;
    logic        qry_pending;
    logic        queue_done;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    // bench model of the two slots
    logic [31:0] m_act_base = '0, m_pnd_base = '0;
    longint      m_act_len = 0, m_act_used = 0, m_pnd_len = 0;
    bit          m_pnd_valid = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_coalesce_queue i_xfer_coalesce_queue (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
        .chunk_valid(chunk_valid), .chunk_addr(chunk_addr), .chunk_words(chunk_words),
        .chunk_ready(chunk_ready),
        .qry_addr(qry_addr), .qry_pending(qry_pending), .queue_done(queue_done)
    );

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_empty();
        return (m_act_len == 0) && !m_pnd_valid;
    endfunction

    // 0 odd, 1 drop, 2 load, 3 grow act, 4 grow pnd, 5 store pnd, 6 reject
    function automatic int exp_op(logic [31:0] a, longint len);
        if (len % 2 != 0) return 0;
        if (len == 0) return 1;
        if (m_empty()) return 2;
        if (!m_pnd_valid && longint'(a) == longint'(m_act_base) + m_act_len) return 3;
        if (m_pnd_valid && longint'(a) == longint'(m_pnd_base) + m_pnd_len) return 4;
        if (!m_pnd_valid) return 5;
        return 6;
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0, 1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic longint exp_words();
        longint w;
        w = (m_act_len - m_act_used) / 2;
        return (w > MAXW) ? MAXW : w;
    endfunction

    function automatic bit exp_hit(logic [31:0] a);
        longint q;
        q = longint'(a);
        if (m_act_used != m_act_len && q >= longint'(m_act_base) + m_act_used
            && q < longint'(m_act_base) + m_act_len) return 1;
        if (m_pnd_valid && q >= longint'(m_pnd_base) && q < longint'(m_pnd_base) + m_pnd_len) return 1;
        return 0;
    endfunction

    // one cycle: drive at falling edge, compare, advance model for the coming edge
    task automatic cyc(bit rv, logic [31:0] a, logic [19:0] len, bit cr, logic [31:0] qa);
        int  op;
        bit  e_ready, e_cv;
        @(negedge clk);
        req_valid = rv; req_addr = a; req_len = len; chunk_ready = cr; qry_addr = qa;
        #1;
        op      = exp_op(a, longint'(len));
        e_ready = (op != 0 && op != 6);
        e_cv    = (m_act_used != m_act_len);
        chk(req_ready == e_ready, op_tag(op), "req_ready", req_ready, e_ready);
        chk(chunk_valid == e_cv, "R8", "chunk_valid", chunk_valid, e_cv);
        if (e_cv) begin
            chk(longint'(chunk_addr) == longint'(m_act_base) + m_act_used, "R8", "chunk_addr",
                chunk_addr, longint'(m_act_base) + m_act_used);
            chk(longint'(chunk_words) == exp_words(), "R8", "chunk_words", chunk_words, exp_words());
        end
        chk(qry_pending == exp_hit(qa), "R11", "qry_pending", qry_pending, exp_hit(qa));
        chk(queue_done == m_empty(), "R12", "queue_done", queue_done, m_empty());
        // model update
        if (rv && e_ready) begin
            case (op)
                2: begin m_act_base = a; m_act_len = longint'(len); m_act_used = 0; end
                3: m_act_len += longint'(len);
                4: m_pnd_len += longint'(len);
                5: begin m_pnd_valid = 1; m_pnd_base = a; m_pnd_len = longint'(len); end
                default: ;
            endcase
        end
        if (cr && e_cv) m_act_used += 2 * exp_words_pre(e_cv);
        if (m_act_len != 0 && m_act_used == m_act_len) begin
            if (m_pnd_valid) begin
                m_act_base = m_pnd_base; m_act_len = m_pnd_len; m_act_used = 0;
                m_pnd_valid = 0; m_pnd_len = 0;
            end else begin
                m_act_len = 0; m_act_used = 0;
            end
        end
    endtask

    // chunk size as offered before this cycle's request update
    longint snap_words = 0;
    function automatic longint exp_words_pre(bit v);
        return v ? snap_words : 0;
    endfunction

    task automatic idle_cyc(logic [31:0] qa);
        snap_words = exp_words();
        cyc(0, 32'h0, 20'h0, 0, qa);
    endtask

    task automatic go(bit rv, logic [31:0] a, logic [19:0] len, bit cr, logic [31:0] qa);
        snap_words = exp_words();
        cyc(rv, a, len, cr, qa);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog R12 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        idle_cyc(32'h2000);
        chk(queue_done == 1'b1, "R1", "done after reset", queue_done, 1);
        chk(chunk_valid == 1'b0, "R1", "chunk_valid after reset", chunk_valid, 0);
        chk(qry_pending == 1'b0, "R1", "qry after reset", qry_pending, 0);

        // R2 odd length refused, zero length dropped
        go(1, 32'h2000, 20'd7, 0, 32'h2000);
        chk(req_ready == 1'b0, "R2", "odd len ready", req_ready, 0);
        go(1, 32'h2000, 20'd0, 0, 32'h2000);
        idle_cyc(32'h2000);
        chk(queue_done == 1'b1, "R2", "done after zero len", queue_done, 1);

        // R3 load when empty
        go(1, 32'h2000, 20'd300, 0, 32'h2000);
        idle_cyc(32'h2000);
        chk(chunk_addr == 32'h2000, "R3", "loaded chunk_addr", chunk_addr, 32'h2000);
        chk(chunk_words == 8'd128, "R8", "first chunk words", chunk_words, 128);

        // R4 grow active to 400 bytes
        go(1, 32'h2000 + 300, 20'd100, 0, 32'h2000);
        idle_cyc(32'h2000 + 399);
        chk(qry_pending == 1'b1, "R4", "grown active tail", qry_pending, 1);

        // R6 store pending, R5 grow it to 60 bytes
        go(1, 32'h8000, 20'd40, 0, 32'h8000);
        go(1, 32'h8028, 20'd20, 0, 32'h8000);
        idle_cyc(32'h8000 + 59);
        chk(qry_pending == 1'b1, "R5", "grown pending tail", qry_pending, 1);
        idle_cyc(32'h8000 + 60);
        chk(qry_pending == 1'b0, "R11", "past pending end", qry_pending, 0);

        // R7 refused: unrelated, and continuing the active one while pending full
        go(1, 32'h9000, 20'd10, 0, 32'h8000);
        chk(req_ready == 1'b0, "R7", "unrelated while full", req_ready, 0);
        go(1, 32'h2000 + 400, 20'd10, 0, 32'h8000);
        chk(req_ready == 1'b0, "R7", "active-contiguous while full", req_ready, 0);

        // R9 hold while not ready
        idle_cyc(32'h2000);
        held = chunk_addr;
        idle_cyc(32'h2000);
        idle_cyc(32'h2000);
        chk(chunk_addr == held, "R9", "held chunk_addr", chunk_addr, held);

        // R8 consume, R10 promote
        go(0, 32'h0, 20'h0, 1, 32'h2000);
        idle_cyc(32'h2000);
        chk(chunk_addr == 32'h2000 + 256, "R8", "advanced addr", chunk_addr, 32'h2000 + 256);
        chk(chunk_words == 8'd72, "R8", "tail words", chunk_words, 72);
        chk(qry_pending == 1'b0, "R11", "consumed part", qry_pending, 0);
        go(0, 32'h0, 20'h0, 1, 32'h2000);
        idle_cyc(32'h2000 + 300);
        chk(chunk_addr == 32'h8000, "R10", "promoted addr", chunk_addr, 32'h8000);
        chk(chunk_words == 8'd30, "R10", "promoted words", chunk_words, 30);
        chk(qry_pending == 1'b0, "R11", "old active gone", qry_pending, 0);
        go(0, 32'h0, 20'h0, 1, 32'h8000);
        idle_cyc(32'h8000);
        chk(queue_done == 1'b1, "R12", "drained", queue_done, 1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a, qa;
            logic [19:0] len;
            int sel;
            bit rv, cr;
            rv  = ($urandom % 3) != 0;
            cr  = ($urandom % 2) != 0;
            sel = int'($urandom % 5);
            case (sel)
                0, 1: a = m_act_base + 32'(m_act_len);
                2:    a = m_pnd_base + 32'(m_pnd_len);
                default: a = (32'h0001_0000 + ($urandom % 32'h0010_0000)) & ~32'h1;
            endcase
            len = 20'((($urandom % 200) + 1) * 2);
            if ($urandom % 12 == 0) len = len | 20'h1;
            if ($urandom % 20 == 0) len = '0;
            if ($urandom % 2 == 0)
                qa = m_act_base + ($urandom % 32'(m_act_len + 8));
            else
                qa = m_pnd_base + ($urandom % 32'(m_pnd_len + 8));
            go(rv, a, len, cr, qa);
        end

        // drain
        for (int i = 0; i < 20000 && !m_empty(); i++)
            go(0, 32'h0, 20'h0, 1, m_act_base);
        idle_cyc(32'h0);
        chk(queue_done == 1'b1, "R12", "final drain", queue_done, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule